// File: doc/BRIEF.md
# Multiplexed display RAM write controller

This block sits behind an already decoded serial command interface and turns a stream of display data bytes into writes to a display RAM. The RAM has 40 columns (segment outputs) and 4 rows (backplanes). A 2-bit drive mode decides how the eight bits of each byte are spread over rows and columns. In static mode a byte fills one row across eight columns. In the 1:2, 1:3 and 1:4 multiplex modes a byte fills short column words of 2, 3 or 4 bits. A column data pointer marks where the next byte starts, and it advances by the number of columns that the byte touched.

Several such blocks can be cascaded so that they behave as one long display. Each block holds a 3-bit subaddress counter and compares it with a fixed hardware address, and it stores a bit only when the two are equal. The pointer advances whether or not a store takes place. When the pointer runs past the last column, it wraps to column 0 and the subaddress counter steps. This can happen partway through a byte, and the remaining bits of that byte then belong to the next device. The block reports a per-byte acknowledge, a pulse on pointer wrap, and a flag that marks the pointer as untrustworthy after an aborted transfer.

Top module: `disp_ram_wr`

## Requirements
- R1: After synchronous reset, the pointer is 0, the subaddress counter is 0, every RAM bit is 0, and ack_o, wrap_o and ptr_bad_o are 0.
- R2: Static mode (mode_i = 0): byte bit 7-k is written to row 0 of column ptr+k, for k = 0..7. Rows 1 to 3 of those columns keep their contents. The RAM bit of column c and row r appears at ram_o[c*4+r].
- R3: 1:2 mode (mode_i = 1): the byte forms four 2-bit words in columns ptr..ptr+3. In each pair, the higher byte bit goes to row 0 and the lower one to row 1. Rows 2 and 3 are unchanged.
- R4: 1:3 mode (mode_i = 2): bits 7,6,5 go to rows 0,1,2 of column ptr, and bits 4,3,2 to rows 0,1,2 of column ptr+1. Bits 1,0 go to rows 0,1 of column ptr+2. Row 2 of column ptr+2 and row 3 of every column are unchanged.
- R5: 1:4 mode (mode_i = 3): bits 7..4 go to rows 0..3 of column ptr, and bits 3..0 go to rows 0..3 of column ptr+1.
- R6: After each accepted byte, the pointer advances by 8, 4, 3 or 2 for modes 0, 1, 2 and 3, modulo 40. The pointer never holds a value of 40 or more.
- R7: A bit is stored only when the subaddress in effect for that bit equals hw_addr_i. On a mismatch, nothing is stored, but the pointer advances exactly as it does when a store takes place.
- R8: When an accepted byte carries the pointer past column 39, the subaddress counter increments modulo 8, and wrap_o pulses for one cycle together with the update. Bits of that byte that land past column 39 go to column (ptr+k-40) under the incremented subaddress.
- R9: ack_o pulses in the cycle after an accepted byte if at least one of its bits was stored. It stays low if none was stored.
- R10: A load-pointer strobe sets the pointer to ptr_val_i, or to 0 when ptr_val_i is 40 or more, and clears ptr_bad_o. A device-select strobe loads sel_val_i into the subaddress counter.
- R11: abort_i sets ptr_bad_o; when abort_i and the load-pointer strobe come in the same cycle, ptr_bad_o ends set. While ptr_bad_o is set, bytes are ignored: no RAM bit changes, the pointer does not move, and ack_o stays low.
- R12: A byte that arrives in the same cycle as a load-pointer, device-select or abort strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Drive mode: 0 static, 1 1:2, 2 1:3, 3 1:4 |
| hw_addr_i | input | 3 | Fixed hardware subaddress of this device |
| ptr_load_i | input | 1 | Load-pointer strobe |
| ptr_val_i | input | 6 | Pointer value for the load-pointer strobe |
| sel_load_i | input | 1 | Device-select strobe |
| sel_val_i | input | 3 | Subaddress value for the device-select strobe |
| byte_valid_i | input | 1 | A display data byte is present |
| byte_data_i | input | 8 | Display data byte |
| abort_i | input | 1 | Early end of transfer |
| ram_o | output | 160 | Display RAM contents, bit c*4+r = column c, row r |
| ptr_o | output | 6 | Current column data pointer |
| sub_o | output | 3 | Current subaddress counter |
| ptr_bad_o | output | 1 | Pointer invalid after an abort |
| ack_o | output | 1 | Byte acknowledge, one cycle after the byte |
| wrap_o | output | 1 | Pointer wrapped past the last column |

## Verification
On every cycle, the assertions check that the pointer stays below 40, that the RAM holds still when no lane is enabled, that every acknowledge and every rise or fall of the invalid flag has a legal cause, that the pointer is frozen while the flag is set, and that each wrap pulse comes with a subaddress increment. The bit placement of each mode cannot be checked that way, and neither can the partial spill of a byte into the next device, the untouched rows, or the clamp of an out-of-range pointer load. These only show in the bench's scenarios. The bench sweeps every start column in every mode and compares the whole RAM against an arithmetic model after each byte.

// File: rtl/disp_ram_pkg.sv
package disp_ram_pkg;

    localparam int BYTE_W = 8;
    localparam int NROWS  = 4;

    typedef enum logic [1:0] {
        MODE_STATIC = 2'd0,
        MODE_MUX2   = 2'd1,
        MODE_MUX3   = 2'd2,
        MODE_MUX4   = 2'd3
    } drive_mode_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } data_byte_t;

    // rows filled per column word in a mode
    function automatic int rows_per_col(drive_mode_e m);
        return int'(m) + 1;
    endfunction

    // columns consumed by one byte in a mode
    function automatic int col_step(drive_mode_e m);
        return (BYTE_W + rows_per_col(m) - 1) / rows_per_col(m);
    endfunction

endpackage

// File: rtl/disp_ram_ptr.sv
module disp_ram_ptr
    import disp_ram_pkg::*;
#(
    parameter int NCOLS = 40,
    parameter int SUB_W = 3,
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  drive_mode_e      mode,
    input  logic             ptr_load,
    input  logic [PTR_W-1:0] ptr_val,
    input  logic             sel_load,
    input  logic [SUB_W-1:0] sel_val,
    input  logic             abort,
    input  logic             byte_valid,
    output logic [PTR_W-1:0] ptr_q,
    output logic [SUB_W-1:0] sub_q,
    output logic             bad_q,
    output logic             accept,
    output logic             wrap_now
);

    localparam logic [PTR_W:0] NCOLS_W = (PTR_W+1)'(NCOLS);

    logic [PTR_W:0]   sum;
    logic [PTR_W-1:0] ptr_next;
    logic [PTR_W-1:0] load_val;

    always_comb begin
        accept   = byte_valid && !bad_q && !ptr_load && !sel_load && !abort;
        sum      = {1'b0, ptr_q} + (PTR_W+1)'(col_step(mode));
        wrap_now = accept && (sum >= NCOLS_W);
        ptr_next = (sum >= NCOLS_W) ? PTR_W'(sum - NCOLS_W) : sum[PTR_W-1:0];
        load_val = ({1'b0, ptr_val} >= NCOLS_W) ? '0 : ptr_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            sub_q <= '0;
            bad_q <= 1'b0;
        end else begin
            if (abort)
                bad_q <= 1'b1;
            else if (ptr_load)
                bad_q <= 1'b0;

            if (ptr_load)
                ptr_q <= load_val;
            else if (accept)
                ptr_q <= ptr_next;

            if (sel_load)
                sub_q <= sel_val;
            else if (wrap_now)
                sub_q <= sub_q + 1'b1;
        end
    end

    assert_ptr_range_R6: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, ptr_q} < NCOLS_W));

    assert_bad_cause_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(bad_q) |-> $past(abort));

    assert_bad_clear_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(bad_q) |-> $past(ptr_load));

    assert_ptr_frozen_R11: assert property (@(posedge clk) disable iff (rst)
        (bad_q && !ptr_load) |=> $stable(ptr_q));

endmodule

// File: rtl/disp_ram_lanes.sv
module disp_ram_lanes
    import disp_ram_pkg::*;
#(
    parameter int NCOLS = 40,
    parameter int SUB_W = 3,
    parameter int PTR_W = 6,
    parameter int ROW_W = 2
) (
    input  drive_mode_e      mode,
    input  logic [PTR_W-1:0] ptr,
    input  logic [SUB_W-1:0] sub,
    input  logic [SUB_W-1:0] hw_addr,
    input  logic             accept,
    input  data_byte_t       din,
    output logic [BYTE_W-1:0] lane_we,
    output logic [BYTE_W-1:0] lane_bit,
    output logic [PTR_W-1:0] lane_col [BYTE_W],
    output logic [ROW_W-1:0] lane_row [BYTE_W],
    output logic             any_hit
);

    localparam logic [PTR_W:0] NCOLS_W = (PTR_W+1)'(NCOLS);

    logic [PTR_W:0]   off     [BYTE_W];
    logic [PTR_W:0]   sum     [BYTE_W];
    logic             spill   [BYTE_W];
    logic [SUB_W-1:0] eff_sub [BYTE_W];

    // lane l carries byte bit (BYTE_W-1-l); its column offset and row
    // follow from l and the number of rows per column word
    always_comb begin
        for (int l = 0; l < BYTE_W; l++) begin
            unique case (mode)
                MODE_STATIC: begin
                    off[l]      = (PTR_W+1)'(l);
                    lane_row[l] = '0;
                end
                MODE_MUX2: begin
                    off[l]      = (PTR_W+1)'(l / 2);
                    lane_row[l] = ROW_W'(l % 2);
                end
                MODE_MUX3: begin
                    off[l]      = (PTR_W+1)'(l / 3);
                    lane_row[l] = ROW_W'(l % 3);
                end
                MODE_MUX4: begin
                    off[l]      = (PTR_W+1)'(l / 4);
                    lane_row[l] = ROW_W'(l % 4);
                end
            endcase
            sum[l]      = {1'b0, ptr} + off[l];
            spill[l]    = (sum[l] >= NCOLS_W);
            lane_col[l] = spill[l] ? PTR_W'(sum[l] - NCOLS_W) : sum[l][PTR_W-1:0];
            eff_sub[l]  = sub + SUB_W'(spill[l]);
            lane_we[l]  = accept && din.valid && (eff_sub[l] == hw_addr);
            lane_bit[l] = din.data[BYTE_W-1-l];
        end
        any_hit = |lane_we;
    end

endmodule

// File: rtl/disp_ram_store.sv
module disp_ram_store
    import disp_ram_pkg::*;
#(
    parameter int NCOLS = 40,
    parameter int PTR_W = 6,
    parameter int ROW_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] lane_we,
    input  logic [BYTE_W-1:0] lane_bit,
    input  logic [PTR_W-1:0]  lane_col [BYTE_W],
    input  logic [ROW_W-1:0]  lane_row [BYTE_W],
    output logic [NCOLS*NROWS-1:0] mem_o
);

    localparam int NBITS = NCOLS * NROWS;
    localparam int IDX_W = $clog2(NBITS);

    logic [NBITS-1:0] mem_q;
    logic [IDX_W-1:0] idx [BYTE_W];

    always_comb begin
        for (int l = 0; l < BYTE_W; l++)
            idx[l] = IDX_W'(lane_col[l]) * IDX_W'(NROWS) + IDX_W'(lane_row[l]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
        end else begin
            for (int l = 0; l < BYTE_W; l++)
                if (lane_we[l])
                    mem_q[idx[l]] <= lane_bit[l];
        end
    end

    // one output slice per column, row order within the slice
    for (genvar c = 0; c < NCOLS; c++) begin : g_col
        assign mem_o[c*NROWS +: NROWS] = mem_q[c*NROWS +: NROWS];
    end

    assert_mem_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(|lane_we) |=> $stable(mem_q));

endmodule

// File: rtl/disp_ram_wr.sv
module disp_ram_wr
    import disp_ram_pkg::*;
#(
    parameter int NCOLS = 40,
    parameter int SUB_W = 3,
    parameter int PTR_W = $clog2(NCOLS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             mode_i,
    input  logic [SUB_W-1:0]       hw_addr_i,
    input  logic                   ptr_load_i,
    input  logic [PTR_W-1:0]       ptr_val_i,
    input  logic                   sel_load_i,
    input  logic [SUB_W-1:0]       sel_val_i,
    input  logic                   byte_valid_i,
    input  logic [BYTE_W-1:0]      byte_data_i,
    input  logic                   abort_i,
    output logic [NCOLS*NROWS-1:0] ram_o,
    output logic [PTR_W-1:0]       ptr_o,
    output logic [SUB_W-1:0]       sub_o,
    output logic                   ptr_bad_o,
    output logic                   ack_o,
    output logic                   wrap_o
);

    localparam int ROW_W = $clog2(NROWS);

    drive_mode_e       mode;
    data_byte_t        din;
    logic              accept;
    logic              wrap_now;
    logic              any_hit;
    logic [BYTE_W-1:0] lane_we;
    logic [BYTE_W-1:0] lane_bit;
    logic [PTR_W-1:0]  lane_col [BYTE_W];
    logic [ROW_W-1:0]  lane_row [BYTE_W];

    assign mode = drive_mode_e'(mode_i);
    assign din  = '{valid: byte_valid_i, data: byte_data_i};

    disp_ram_ptr #(.NCOLS(NCOLS), .SUB_W(SUB_W), .PTR_W(PTR_W)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .ptr_load   (ptr_load_i),
        .ptr_val    (ptr_val_i),
        .sel_load   (sel_load_i),
        .sel_val    (sel_val_i),
        .abort      (abort_i),
        .byte_valid (byte_valid_i),
        .ptr_q      (ptr_o),
        .sub_q      (sub_o),
        .bad_q      (ptr_bad_o),
        .accept     (accept),
        .wrap_now   (wrap_now)
    );

    disp_ram_lanes #(.NCOLS(NCOLS), .SUB_W(SUB_W), .PTR_W(PTR_W), .ROW_W(ROW_W)) u_lanes (
        .mode     (mode),
        .ptr      (ptr_o),
        .sub      (sub_o),
        .hw_addr  (hw_addr_i),
        .accept   (accept),
        .din      (din),
        .lane_we  (lane_we),
        .lane_bit (lane_bit),
        .lane_col (lane_col),
        .lane_row (lane_row),
        .any_hit  (any_hit)
    );

    disp_ram_store #(.NCOLS(NCOLS), .PTR_W(PTR_W), .ROW_W(ROW_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .lane_we  (lane_we),
        .lane_bit (lane_bit),
        .lane_col (lane_col),
        .lane_row (lane_row),
        .mem_o    (ram_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_o  <= 1'b0;
            wrap_o <= 1'b0;
        end else begin
            ack_o  <= accept && any_hit;
            wrap_o <= wrap_now;
        end
    end

    assert_ack_cause_R9: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> $past(accept));

    assert_wrap_sub_R8: assert property (@(posedge clk) disable iff (rst)
        wrap_o |-> (sub_o == SUB_W'($past(sub_o) + 1'b1)));

    assert_ignore_strobe_R12: assert property (@(posedge clk) disable iff (rst)
        (byte_valid_i && (sel_load_i || abort_i) && !ptr_load_i) |=> $stable(ptr_o));

endmodule

// File: tb/disp_ram_wr_bench.sv
`timescale 1ns/1ps
module disp_ram_wr_bench;

    localparam int NC = 40;
    localparam int NR = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'd0;
    logic [2:0]    hw_addr = 3'd5;
    logic          ptr_load = 1'b0;
    logic [5:0]    ptr_val = '0;
    logic          sel_load = 1'b0;
    logic [2:0]    sel_val = '0;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          abort = 1'b0;
    logic [NC*NR-1:0] ram;
    logic [5:0]    ptr;
    logic [2:0]    sub;
    logic          ptr_bad, ack, wrap;

    disp_ram_wr u_disp_ram_wr (
        .clk(clk), .rst(rst), .mode_i(mode), .hw_addr_i(hw_addr),
        .ptr_load_i(ptr_load), .ptr_val_i(ptr_val),
        .sel_load_i(sel_load), .sel_val_i(sel_val),
        .byte_valid_i(byte_valid), .byte_data_i(byte_data), .abort_i(abort),
        .ram_o(ram), .ptr_o(ptr), .sub_o(sub), .ptr_bad_o(ptr_bad),
        .ack_o(ack), .wrap_o(wrap)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit mdl [NC][NR];
    int mptr = 0;
    int msub = 0;
    int mhw = 5;
    bit mbad = 0;
    bit exp_ack = 0;
    bit exp_wrap = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_ram(input string tag);
        int bad = 0;
        for (int c = 0; c < NC; c++)
            for (int r = 0; r < NR; r++)
                if (ram[c*NR+r] !== mdl[c][r]) bad++;
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic chk_state(input string tag);
        chk(ptr == 6'(mptr), {tag, " ptr"}, int'(ptr), mptr);
        chk(sub == 3'(msub), {tag, " sub"}, int'(sub), msub);
        chk(ptr_bad == mbad, {tag, " bad"}, int'(ptr_bad), int'(mbad));
        chk_ram({tag, " ram"});
    endtask

    // arithmetic model of one byte
    task automatic model_byte(input int m, input logic [7:0] d);
        int rpc = m + 1;
        int step = (8 + rpc - 1) / rpc;
        exp_ack = 0;
        exp_wrap = 0;
        if (mbad) return;
        for (int i = 0; i < 8; i++) begin
            int c = mptr + i / rpc;
            int s = msub;
            if (c >= NC) begin
                c -= NC;
                s = (s + 1) % 8;
            end
            if (s == mhw) begin
                mdl[c][i % rpc] = d[7-i];
                exp_ack = 1;
            end
        end
        if (mptr + step >= NC) begin
            exp_wrap = 1;
            msub = (msub + 1) % 8;
        end
        mptr = (mptr + step) % NC;
    endtask

    task automatic load_ptr(input int v);
        @(negedge clk);
        ptr_load = 1'b1;
        ptr_val = 6'(v);
        @(negedge clk);
        ptr_load = 1'b0;
        mptr = (v >= NC) ? 0 : v;
        mbad = 0;
    endtask

    task automatic load_sel(input int v);
        @(negedge clk);
        sel_load = 1'b1;
        sel_val = 3'(v);
        @(negedge clk);
        sel_load = 1'b0;
        msub = v;
    endtask

    task automatic send_byte(input int m, input logic [7:0] d, input string tag);
        @(negedge clk);
        mode = 2'(m);
        byte_valid = 1'b1;
        byte_data = d;
        model_byte(m, d);
        @(negedge clk);
        byte_valid = 1'b0;
        chk(ack == exp_ack, {tag, " R9 ack"}, int'(ack), int'(exp_ack));
        chk(wrap == exp_wrap, {tag, " R8 wrap"}, int'(wrap), int'(exp_wrap));
        chk_state(tag);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    string mtag [4] = '{"R2 static", "R3 mux2", "R4 mux3", "R5 mux4"};
    int order [4] = '{3, 0, 1, 2};

    initial begin
        for (int c = 0; c < NC; c++)
            for (int r = 0; r < NR; r++) mdl[c][r] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ack == 1'b0, "R1 ack", int'(ack), 0);
        chk(wrap == 1'b0, "R1 wrap", int'(wrap), 0);
        chk_state("R1 reset");

        // sweep of every start column in every mode (1:4 first so
        // all rows are populated before the modes that leave rows alone)
        mhw = 5;
        hw_addr = 3'd5;
        for (int k = 0; k < 4; k++) begin
            for (int p = 0; p < NC; p++) begin
                load_ptr(p);
                load_sel(5);
                send_byte(order[k], 8'((p * 73 + order[k] * 29 + 17) & 255),
                          {mtag[order[k]], " R6 sweep"});
            end
        end

        // R8 R7 streaming 1:3 through the end of the RAM into the next device
        load_ptr(0);
        load_sel(5);
        for (int b = 0; b < 18; b++)
            send_byte(2, 8'(b * 41 + 3), "R8 R7 stream");

        // R8 mid-byte spill into this device from the previous one
        mhw = 3;
        hw_addr = 3'd3;
        load_sel(2);
        load_ptr(38);
        send_byte(0, 8'hA7, "R8 spill in");
        // R8 spill out of this device
        load_sel(3);
        load_ptr(38);
        send_byte(0, 8'h5C, "R8 spill out");

        // R7 complete mismatch: no store, no ack, pointer still moves
        load_sel(1);
        load_ptr(10);
        send_byte(3, 8'hFF, "R7 mismatch");
        send_byte(1, 8'h00, "R7 mismatch");

        // R8 subaddress wraps modulo 8
        load_sel(7);
        load_ptr(36);
        send_byte(3, 8'h3C, "R8 sub modulo");
        send_byte(3, 8'hC3, "R8 sub modulo");

        // R10 pointer clamp and select load
        load_ptr(40);
        chk_state("R10 clamp 40");
        load_ptr(63);
        chk_state("R10 clamp 63");
        load_ptr(39);
        chk_state("R10 load 39");
        load_sel(6);
        chk_state("R10 sel");

        // R11 abort, ignored bytes, recovery
        load_sel(3);
        load_ptr(20);
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        mbad = 1;
        chk_state("R11 abort");
        send_byte(0, 8'hFF, "R11 ignored");
        send_byte(3, 8'hFF, "R11 ignored");
        load_ptr(20);
        chk_state("R10 clear bad");
        send_byte(3, 8'h96, "R11 recovered");
        // abort together with load-pointer leaves the flag set
        @(negedge clk);
        abort = 1'b1;
        ptr_load = 1'b1;
        ptr_val = 6'd5;
        @(negedge clk);
        abort = 1'b0;
        ptr_load = 1'b0;
        mptr = 5;
        mbad = 1;
        chk_state("R11 abort+load");
        load_ptr(5);

        // R12 byte in the same cycle as a strobe is ignored
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data = 8'hFF;
        mode = 2'd3;
        ptr_load = 1'b1;
        ptr_val = 6'd30;
        @(negedge clk);
        byte_valid = 1'b0;
        ptr_load = 1'b0;
        mptr = 30;
        chk(ack == 1'b0, "R12 ack load", int'(ack), 0);
        chk_state("R12 with load");
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data = 8'hFF;
        sel_load = 1'b1;
        sel_val = 3'd3;
        @(negedge clk);
        byte_valid = 1'b0;
        sel_load = 1'b0;
        msub = 3;
        chk(ack == 1'b0, "R12 ack sel", int'(ack), 0);
        chk_state("R12 with sel");
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data = 8'hFF;
        abort = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0;
        abort = 1'b0;
        mbad = 1;
        chk(ack == 1'b0, "R12 ack abort", int'(ack), 0);
        chk_state("R12 with abort");

        finish_run();
    end

endmodule